// File: doc/BRIEF.md
# Serial Flash Sequential Read Responder

This block is the device side of a serial memory port. A host selects it by pulling `cs_n` low, clocks in an 8-bit command followed by a 24-bit start address on `mosi`, and then keeps clocking to receive stored bytes on `so_d`. The address steps forward after every byte, so one command can stream the whole array. The host ends the transfer by raising `cs_n`, which it may do at any bit, including partway through a byte.

The contents sit in a byte array of `2**MEM_AW` entries. The default is small so that elaboration stays light; 16 gives the full 64K x 8 array. The array is filled through a plain load port that a separate write engine would own. That engine also drives `busy`. A read command that arrives while `busy` is high is dropped, and the engine's cycle is left alone. The output is tri-state capable: `so_oe` is the enable and `so_d` is the value, and the pad combines them. The serial stream has no valid/ready handshake. The host sets the pace purely by clocking, and it applies back-pressure only by stopping `sclk` or by deselecting.

Top module: `spi_rd_responder`

## Requirements
- R1: While `cs_n` is high, `so_oe` is low. Raising `cs_n` at any point, including mid-byte, drops `so_oe` at once, without waiting for a clock.
- R2: The header is 32 bits sampled on rising `sclk` edges, most significant bit first: an 8-bit command, then a 24-bit address. The read command code is 0x03.
- R3: Data is shifted out most significant bit first. Bits change on falling `sclk` edges. The first bit appears on the falling edge that follows the 32nd rising edge. The start address may be any location.
- R4: `so_oe` stays low throughout the 32 header bits.
- R5: After each full byte the address advances by one, and output continues for as long as the host keeps clocking with `cs_n` low.
- R6: There is no wrap-around. Once the byte at the top address (`2**MEM_AW-1`) has been sent, every further byte reads 0xFF and the address holds.
- R7: Address bits 23 down to `MEM_AW` must be zero. If any of them is set, every byte returned is 0xFF.
- R8: A command code other than 0x03 produces no output until `cs_n` goes high.
- R9: If `busy` is high at the 8th rising edge, the read is rejected: no output until deselect, and the stored contents are unchanged.
- R10: `busy` is looked at only on the 8th rising edge. Its value during the address or data phase has no effect.
- R11: After any deselect, the next selection decodes a fresh header from its first bit.
- R12: With `ld_en` high, a rising `sclk` edge writes `ld_data` to `ld_addr`, and a later read returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host; rising edge samples, falling edge drives |
| cs_n | input | 1 | Active-low select; high acts as an asynchronous reset of the transfer |
| mosi | input | 1 | Serial command/address input |
| busy | input | 1 | High while the write/erase engine has a cycle in progress |
| ld_en | input | 1 | Load strobe from the write engine |
| ld_addr | input | MEM_AW | Load address |
| ld_data | input | 8 | Load data |
| so_d | output | 1 | Serial data value |
| so_oe | output | 1 | Output enable; low means high impedance |

## Verification
The command decision, including the `busy` sample, is due on the 8th rising edge. The start address is complete on the 32nd rising edge, and the first data bit lands on the falling edge right after it. Each later bit arrives one falling edge after the previous one. The bench drives inputs 1 ns after each falling edge and reads `so_d` 1 ns after each rising edge, so every observed bit was driven a half period earlier and is stable. The effect of deselect is checked half a nanosecond after `cs_n` rises, because the release does not depend on any clock edge.

// File: rtl/spi_rd_pkg.sv
`timescale 1ns/1ps
package spi_rd_pkg;
  localparam int CMD_BITS = 8;
  localparam int ADR_BITS = 24;
  localparam logic [7:0] OP_READ = 8'h03;
  typedef enum logic [1:0] {PH_CMD, PH_ADR, PH_DATA, PH_DEAD} phase_e;
endpackage

// File: rtl/rd_byte_array.sv
`timescale 1ns/1ps
module rd_byte_array #(
  parameter int MEM_AW = 10
) (
  input  logic              sclk,
  input  logic              ld_en,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge sclk) begin
    if (ld_en) cells[ld_addr] <= ld_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/rd_cmd_decoder.sv
`timescale 1ns/1ps
module rd_cmd_decoder
  import spi_rd_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              busy,
  output phase_e            phase,
  output logic [MEM_AW-1:0] start_addr,
  output logic              start_over
);
  localparam int CW = $clog2(ADR_BITS);

  logic [CW-1:0]         cnt;
  logic [ADR_BITS-2:0]   sh;
  logic [ADR_BITS-1:0]   word;

  assign word = {sh, mosi};

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      phase      <= PH_CMD;
      cnt        <= '0;
      sh         <= '0;
      start_addr <= '0;
      start_over <= 1'b0;
    end else begin
      sh <= word[ADR_BITS-2:0];
      unique case (phase)
        PH_CMD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CMD_BITS - 1)) begin
            cnt   <= '0;
            phase <= (word[7:0] == OP_READ && !busy) ? PH_ADR : PH_DEAD;
          end
        end
        PH_ADR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ADR_BITS - 1)) begin
            phase      <= PH_DATA;
            start_addr <= word[MEM_AW-1:0];
            start_over <= |word[ADR_BITS-1:MEM_AW];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rd_byte_streamer.sv
`timescale 1ns/1ps
module rd_byte_streamer
  import spi_rd_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  phase_e            phase,
  input  logic [MEM_AW-1:0] start_addr,
  input  logic              start_over,
  input  logic [7:0]        rd_data,
  output logic [MEM_AW-1:0] rd_addr,
  output logic              so_d,
  output logic              so_oe
);
  localparam logic [MEM_AW-1:0] TOP = '1;

  logic [2:0]        nbit;
  logic [7:0]        hold;
  logic [MEM_AW-1:0] ptr;
  logic              over;
  logic              fetch_over;
  logic [7:0]        fetched;

  assign rd_addr    = so_oe ? ptr : start_addr;
  assign fetch_over = so_oe ? over : start_over;
  assign fetched    = fetch_over ? 8'hFF : rd_data;

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      so_oe <= 1'b0;
      so_d  <= 1'b0;
      nbit  <= '0;
      hold  <= '0;
      ptr   <= '0;
      over  <= 1'b0;
    end else if (phase == PH_DATA) begin
      so_oe <= 1'b1;
      nbit  <= nbit + 1'b1;
      if (nbit == 3'd0) begin
        hold <= fetched;
        so_d <= fetched[7];
        ptr  <= rd_addr;
        over <= fetch_over;
      end else begin
        so_d <= hold[3'd7 - nbit];
      end
      if (nbit == 3'd7) begin
        if (over || ptr == TOP) over <= 1'b1;
        else                    ptr  <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_rd_responder.sv
`timescale 1ns/1ps
module spi_rd_responder
  import spi_rd_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              busy,
  input  logic              ld_en,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  output logic              so_d,
  output logic              so_oe
);
  phase_e            phase;
  logic [MEM_AW-1:0] start_addr;
  logic              start_over;
  logic [MEM_AW-1:0] rd_addr;
  logic [7:0]        rd_data;

  rd_cmd_decoder #(.MEM_AW(MEM_AW)) u_dec (
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy),
    .phase(phase), .start_addr(start_addr), .start_over(start_over)
  );

  rd_byte_array #(.MEM_AW(MEM_AW)) u_mem (
    .sclk(sclk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  rd_byte_streamer #(.MEM_AW(MEM_AW)) u_out (
    .sclk(sclk), .cs_n(cs_n), .phase(phase), .start_addr(start_addr),
    .start_over(start_over), .rd_data(rd_data), .rd_addr(rd_addr),
    .so_d(so_d), .so_oe(so_oe)
  );
endmodule

// File: rtl/spi_rd_responder_chk.sv
`timescale 1ns/1ps
module spi_rd_responder_chk (
  input logic sclk,
  input logic cs_n,
  input logic busy,
  input logic so_oe
);
  logic [5:0] edges;
  logic       rej;

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      edges <= '0;
      rej   <= 1'b0;
    end else begin
      if (edges != 6'd40) edges <= edges + 1'b1;
      if (edges == 6'd7 && busy) rej <= 1'b1;
    end
  end

  a_r1_quiet_deselected: assert property (@(posedge sclk) cs_n |-> !so_oe);

  a_r4_quiet_header: assert property (@(posedge sclk) disable iff (cs_n)
    (edges < 6'd32) |-> !so_oe);

  a_r9_busy_reject: assert property (@(posedge sclk) disable iff (cs_n)
    rej |-> !so_oe);

  a_r5_drive_holds: assert property (@(posedge sclk) disable iff (cs_n)
    $past(so_oe) |-> so_oe);
endmodule

bind spi_rd_responder spi_rd_responder_chk u_chk (
  .sclk(sclk), .cs_n(cs_n), .busy(busy), .so_oe(so_oe)
);

// File: tb/sim_spi_rd_responder.sv
`timescale 1ns/100ps
module sim_spi_rd_responder;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic cs_n = 1'b1, mosi = 1'b0, busy = 1'b0, ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;
  logic so_d, so_oe;

  int total = 0, bad = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];

  spi_rd_responder #(.MEM_AW(AW)) u0 (
    .sclk(clk), .cs_n(cs_n), .mosi(mosi), .busy(busy),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .so_d(so_d), .so_oe(so_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [23:0] adr, input int nbytes);
    int a = int'(adr[AW-1:0]);
    bit over = (adr[23:AW] != 0);
    for (int k = 0; k < nbytes; k++) begin
      exp_q.push_back(over ? 8'hFF : model[a]);
      if (a == DEPTH - 1) over = 1'b1;
      else if (!over) a++;
    end
  endtask

  task automatic load(input int a, input logic [7:0] d);
    @(negedge clk); #1;
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d; model[a] = d;
  endtask

  task automatic txn(input logic [7:0] op, input logic [23:0] adr, input int nbits,
                     input int busy_lo, input int busy_hi, input bit want, input string tag);
    logic [31:0] hdr = {op, adr};
    bit hq = 1'b0, saw = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); #1;
      if (i == 0) cs_n = 1'b0;
      mosi = hdr[31-i];
      busy = (i >= busy_lo && i <= busy_hi);
      hq |= so_oe;
    end
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); #1;
      busy = 1'b0;
      saw |= so_oe;
    end
    @(negedge clk); #1;
    cs_n = 1'b1; busy = 1'b0; mosi = 1'b0;
    #0.5;
    chk("R1 released on deselect", so_oe, 0);
    chk("R4 header quiet", hq, 0);
    chk({tag, " output enable"}, saw, want);
    repeat (3) @(negedge clk);
  endtask

  int mbits = 0;
  logic [7:0] macc = '0;
  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (cs_n || !so_oe) mbits = 0;
      else begin
        macc = {macc[6:0], so_d};
        mbits++;
        if (mbits == 8) begin
          mbits = 0;
          if (exp_q.size() == 0) chk("R3 unexpected byte", macc, 32'hDEAD);
          else chk("R3 R5 stream byte", macc, exp_q.pop_front());
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    #5;
    chk("R1 reset state", so_oe, 0);
    for (int a = 0; a < DEPTH; a++) load(a, 8'(a * 37 + 8'h5A) ^ 8'(a >> 3));
    @(negedge clk); #1; ld_en = 1'b0;
    repeat (2) @(negedge clk);

    push_exp(24'h000010, 4); txn(8'h03, 24'h000010, 32, -1, -1, 1'b1, "R2 R5 basic");
    push_exp(24'h0001A7, 3); txn(8'h03, 24'h0001A7, 24, -1, -1, 1'b1, "R3 any start");
    push_exp(24'h0003FE, 4); txn(8'h03, 24'h0003FE, 32, -1, -1, 1'b1, "R6 top");
    push_exp(24'h010005, 2); txn(8'h03, 24'h010005, 16, -1, -1, 1'b1, "R7 high bits");
    txn(8'h0B, 24'h000010, 16, -1, -1, 1'b0, "R8 other opcode");
    txn(8'h03, 24'h000020, 16, 7, 7, 1'b0, "R9 busy reject");
    push_exp(24'h000020, 2); txn(8'h03, 24'h000020, 16, -1, -1, 1'b1, "R9 contents kept");
    push_exp(24'h000030, 2); txn(8'h03, 24'h000030, 16, 8, 31, 1'b1, "R10 busy late");
    push_exp(24'h000040, 1); txn(8'h03, 24'h000040, 11, -1, -1, 1'b1, "R1 mid-byte stop");
    push_exp(24'h000050, 1); txn(8'h03, 24'h000050, 8, -1, -1, 1'b1, "R11 restart");
    load(16'h60, 8'hC3);
    @(negedge clk); #1; ld_en = 1'b0;
    push_exp(24'h000060, 1); txn(8'h03, 24'h000060, 8, -1, -1, 1'b1, "R12 load port");

    repeat (4) @(negedge clk);
    chk("R3 all bytes delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule